// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a fully associative, software-managed address translation buffer. Each slot holds an effective page number, a 3-bit page-size code, a valid flag, a real page number and an 8-bit translation tag. Software fills slots one at a time through an indexed write port. Because every slot carries its own size code, pages from 1 KB up to 16 MB can sit side by side in the same table.

A lookup presents a 32-bit effective address, the current process tag and a relocation-enable flag. The result appears one clock later. It is either a hit with a physical address or a miss that the caller turns into a translation fault. When relocation is off, the effective address passes straight through as the physical address.

Top module: `vtlb_top`

## Requirements
- R1: Reset clears every slot's valid flag. A relocated lookup made after reset and before any valid write reports a miss.
- R2: A write updates every field of the indexed slot in one cycle. A lookup issued in that same cycle still sees the slot's previous contents, and a lookup issued in any later cycle sees the new contents.
- R3: A slot takes part in a lookup only if its valid flag is 1 and its tag equals the lookup's process tag.
- R4: A size code c keeps address bits 31 down to 10+2c for comparison. The masks are: code 0 = FFFFFC00 (1 KB), code 1 = FFFFF000 (4 KB), code 2 = FFFFC000 (16 KB), code 3 = FFFF0000 (64 KB), code 4 = FFFC0000 (256 KB), code 5 = FFF00000 (1 MB), code 6 = FFC00000 (4 MB), code 7 = FF000000 (16 MB).
- R5: A participating slot matches when the effective address and the stored effective page agree on every bit inside the slot's mask. Changing any one masked bit of the address turns the match into a miss.
- R6: On a hit, the physical address takes the stored real page bits inside the mask and the effective address bits outside it.
- R7: When several slots match, the slot with the lowest index supplies the physical address.
- R8: With relocation disabled, the lookup reports a hit with the physical address equal to the effective address, whatever the table holds.
- R9: With relocation enabled and no matching slot, the lookup reports a miss, no hit, and a physical address of zero.
- R10: The response valid flag is 1 exactly one cycle after a lookup request. In any cycle without a response, the hit and miss flags are 0. Hit and miss are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | $clog2(ENTRIES) | Slot index to write |
| wr_epn | input | 32 | Effective page word; only the bits inside the mask are used |
| wr_size | input | 3 | Page-size code (R4) |
| wr_vld | input | 1 | Valid flag to store |
| wr_rpn | input | 32 | Real page word; only the bits inside the mask are used |
| wr_tid | input | TID_W | Translation tag to store |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_pid | input | TID_W | Current process tag |
| lk_reloc | input | 1 | 1 = translate, 0 = pass the address through |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded or was bypassed |
| rsp_miss | output | 1 | No matching slot (translation fault) |
| rsp_pa | output | 32 | Physical address, or zero on a miss |

## Verification
The bench builds the block with ENTRIES set to 8 and TID_W left at 8. With only eight slots, the highest index, several overlapping matches at once, and a full sweep that clears every slot all fit in a few dozen cycles, while the slot logic and the priority logic stay the same as at 64 slots. Each of the eight size codes is tested at both edges of its page: an offset that differs in every unmasked bit must hit, and a flip of the lowest masked bit must miss. Tag mismatch, a cleared valid flag, pass-through mode, and a write and a lookup in the same cycle are each covered by a scenario of their own.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int AW       = 32;
  localparam int SZW      = 3;
  localparam int MIN_PAGE = 10;

  typedef logic [AW-1:0]  addr_t;
  typedef logic [SZW-1:0] size_t;

  // compare mask: keeps bits 31 down to 10+2*code
  function automatic addr_t size_mask(input size_t code);
    return {AW{1'b1}} << (MIN_PAGE + 2 * int'(code));
  endfunction
endpackage

// File: rtl/vtlb_entry.sv
module vtlb_entry
  import vtlb_pkg::*;
#(
  parameter int TID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  addr_t            w_epn,
  input  size_t            w_size,
  input  logic             w_vld,
  input  addr_t            w_rpn,
  input  logic [TID_W-1:0] w_tid,
  input  addr_t            q_ea,
  input  logic [TID_W-1:0] q_pid,
  output logic             hit,
  output addr_t            pa
);
  logic             vld;
  addr_t            epn;
  addr_t            rpn;
  size_t            size;
  logic [TID_W-1:0] tid;
  addr_t            mask;

  always_ff @(posedge clk) begin
    if (rst)     vld <= 1'b0;
    else if (we) vld <= w_vld;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      epn  <= w_epn;
      rpn  <= w_rpn;
      size <= w_size;
      tid  <= w_tid;
    end
  end

  always_comb begin
    mask = size_mask(size);
    hit  = vld && (tid == q_pid) && (((q_ea ^ epn) & mask) == '0);
    pa   = (rpn & mask) | (q_ea & ~mask);
  end
endmodule

// File: rtl/vtlb_pick.sv
module vtlb_pick
  import vtlb_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0] hit,
  input  addr_t        pa_in [N],
  output logic         any,
  output addr_t        pa_out
);
  always_comb begin
    any    = |hit;
    pa_out = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) pa_out = pa_in[i];
    end
  end
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_epn,
  input  logic [2:0]       wr_size,
  input  logic             wr_vld,
  input  logic [31:0]      wr_rpn,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             lk_req,
  input  logic [31:0]      lk_ea,
  input  logic [TID_W-1:0] lk_pid,
  input  logic             lk_reloc,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [31:0]      rsp_pa
);
  logic [ENTRIES-1:0] slot_hit;
  addr_t              slot_pa [ENTRIES];
  logic               any_hit;
  addr_t              sel_pa;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    vtlb_entry #(.TID_W(TID_W)) u_entry (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && (wr_idx == IDX_W'(i))),
      .w_epn  (wr_epn),
      .w_size (wr_size),
      .w_vld  (wr_vld),
      .w_rpn  (wr_rpn),
      .w_tid  (wr_tid),
      .q_ea   (lk_ea),
      .q_pid  (lk_pid),
      .hit    (slot_hit[i]),
      .pa     (slot_pa[i])
    );
  end

  vtlb_pick #(.N(ENTRIES)) u_pick (
    .hit    (slot_hit),
    .pa_in  (slot_pa),
    .any    (any_hit),
    .pa_out (sel_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && (!lk_reloc || any_hit);
      rsp_miss  <= lk_req && lk_reloc && !any_hit;
      if (!lk_req)       rsp_pa <= '0;
      else if (!lk_reloc) rsp_pa <= lk_ea;
      else if (any_hit)   rsp_pa <= sel_pa;
      else                rsp_pa <= '0;
    end
  end
endmodule

// File: rtl/vtlb_checker.sv
module vtlb_checker #(
  parameter int ENTRIES = 64,
  parameter int TID_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_vld,
  input logic             lk_req,
  input logic [31:0]      lk_ea,
  input logic             lk_reloc,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic [31:0]      rsp_pa
);
  logic any_written;

  always_ff @(posedge clk) begin
    if (rst)                  any_written <= 1'b0;
    else if (wr_en && wr_vld) any_written <= 1'b1;
  end

  p_empty_miss_r1: assert property (@(posedge clk) disable iff (rst)
    (!any_written && lk_req && lk_reloc) |=> rsp_miss);

  p_offset_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_reloc) |=> (!rsp_hit || rsp_pa[9:0] == $past(lk_ea[9:0])));

  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !lk_reloc) |=> (rsp_hit && !rsp_miss && rsp_pa == $past(lk_ea)));

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_pa == 32'h0));

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_miss));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_miss));

  // wr_idx only observed to keep the port list aligned with the top
  logic unused_idx;
  assign unused_idx = ^wr_idx;
endmodule

bind vtlb_top vtlb_checker #(.ENTRIES(ENTRIES), .TID_W(TID_W)) u_vtlb_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_vld    (wr_vld),
  .lk_req    (lk_req),
  .lk_ea     (lk_ea),
  .lk_reloc  (lk_reloc),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_pa    (rsp_pa)
);

// File: tb/vtlb_top_bench.sv
`timescale 1ns/1ps
module vtlb_top_bench;
  localparam int N   = 8;
  localparam int IW  = $clog2(N);
  localparam int TW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_epn = '0;
  logic [2:0]    wr_size = '0;
  logic          wr_vld = 1'b0;
  logic [31:0]   wr_rpn = '0;
  logic [TW-1:0] wr_tid = '0;
  logic          lk_req = 1'b0;
  logic [31:0]   lk_ea = '0;
  logic [TW-1:0] lk_pid = '0;
  logic          lk_reloc = 1'b0;
  logic          rsp_valid, rsp_hit, rsp_miss;
  logic [31:0]   rsp_pa;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vtlb_top #(.ENTRIES(N), .TID_W(TW)) u_vtlb_top (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_epn(wr_epn), .wr_size(wr_size),
    .wr_vld(wr_vld), .wr_rpn(wr_rpn), .wr_tid(wr_tid),
    .lk_req(lk_req), .lk_ea(lk_ea), .lk_pid(lk_pid), .lk_reloc(lk_reloc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa)
  );

  function automatic logic [31:0] bmask(input int code);
    case (code)
      0: return 32'hFFFFFC00;
      1: return 32'hFFFFF000;
      2: return 32'hFFFFC000;
      3: return 32'hFFFF0000;
      4: return 32'hFFFC0000;
      5: return 32'hFFF00000;
      6: return 32'hFFC00000;
      default: return 32'hFF000000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] epn, input int sz,
                    input logic vld, input logic [31:0] rpn, input logic [TW-1:0] tid);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_epn = epn; wr_size = 3'(sz);
    wr_vld = vld; wr_rpn = rpn; wr_tid = tid;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wr(i, 32'h0, 0, 1'b0, 32'h0, '0);
  endtask

  // issue lookup; response sampled at the negedge after the capturing edge
  task automatic look(input logic [31:0] ea, input logic [TW-1:0] pid, input logic reloc);
    @(negedge clk);
    lk_req = 1'b1; lk_ea = ea; lk_pid = pid; lk_reloc = reloc;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic exp_hit(input string tag, input logic [31:0] ea,
                         input logic [TW-1:0] pid, input logic [31:0] pa);
    look(ea, pid, 1'b1);
    chk({tag, " flags"}, {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h6);
    chk({tag, " pa"}, rsp_pa, pa);
  endtask

  task automatic exp_miss(input string tag, input logic [31:0] ea, input logic [TW-1:0] pid);
    look(ea, pid, 1'b1);
    chk({tag, " flags"}, {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h5);
    chk({tag, " pa"}, rsp_pa, 32'h0);
  endtask

  task automatic t_reset();
    chk("R10 idle after reset", {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h0);
    exp_miss("R1 empty table", 32'h0000_0000, 8'h00);
    exp_miss("R1 empty table 2", 32'hDEAD_BEEF, 8'h00);
    @(negedge clk);
    chk("R10 no response without request", {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h0);
  endtask

  task automatic t_sizes();
    logic [31:0] e, p, m, ea_in, ea_out;
    e = 32'hA5C3_9E17;
    p = 32'h5A3C_61E8;
    for (int c = 0; c < 8; c++) begin
      m = bmask(c);
      wr(0, e, c, 1'b1, p, 8'h05);
      ea_in  = (e & m) | (~e & ~m);
      ea_out = ea_in ^ (m & (~m + 32'h1));
      exp_hit($sformatf("R4 R6 size %0d inside", c), ea_in, 8'h05, (p & m) | (ea_in & ~m));
      exp_hit($sformatf("R5 size %0d page base", c), e & m, 8'h05, p & m);
      exp_miss($sformatf("R5 size %0d low mask bit", c), ea_out, 8'h05);
      exp_miss($sformatf("R5 size %0d top bit", c), ea_in ^ 32'h8000_0000, 8'h05);
    end
    clear_all();
  endtask

  task automatic t_tag();
    wr(3, 32'h0040_0000, 1, 1'b1, 32'h7770_0000, 8'h03);
    exp_miss("R3 tag mismatch", 32'h0040_0123, 8'h04);
    exp_hit("R3 tag match", 32'h0040_0123, 8'h03, 32'h7770_0123);
    wr(3, 32'h0040_0000, 1, 1'b0, 32'h7770_0000, 8'h03);
    exp_miss("R3 invalid slot", 32'h0040_0123, 8'h03);
    clear_all();
  endtask

  task automatic t_priority();
    wr(5, 32'h1000_0000, 3, 1'b1, 32'h5500_0000, 8'h09);
    wr(2, 32'h1000_0000, 7, 1'b1, 32'h2200_0000, 8'h09);
    exp_hit("R7 lowest wins", 32'h1000_4321, 8'h09, 32'h2200_4321);
    wr(2, 32'h1000_0000, 7, 1'b0, 32'h2200_0000, 8'h09);
    exp_hit("R7 next slot after invalidate", 32'h1000_4321, 8'h09, 32'h5500_4321);
    wr(N - 1, 32'hF000_0000, 6, 1'b1, 32'h0C00_0000, 8'h01);
    exp_hit("R7 last slot", 32'hF012_3456, 8'h01, 32'h0C12_3456);
    clear_all();
  endtask

  task automatic t_bypass();
    look(32'h8765_4321, 8'h00, 1'b0);
    chk("R8 bypass flags", {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h6);
    chk("R8 bypass pa", rsp_pa, 32'h8765_4321);
    wr(0, 32'h8765_4000, 0, 1'b1, 32'h0000_0000, 8'h00);
    look(32'h8765_4321, 8'h00, 1'b0);
    chk("R8 bypass ignores match", rsp_pa, 32'h8765_4321);
    clear_all();
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(1); wr_epn = 32'h0300_0000; wr_size = 3'd2;
    wr_vld = 1'b1; wr_rpn = 32'h0900_0000; wr_tid = 8'h0A;
    lk_req = 1'b1; lk_ea = 32'h0300_1111; lk_pid = 8'h0A; lk_reloc = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    chk("R2 same-cycle lookup sees old", {29'h0, rsp_valid, rsp_hit, rsp_miss}, 32'h5);
    exp_hit("R2 next lookup sees new", 32'h0300_1111, 8'h0A, 32'h0900_1111);
    clear_all();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_tag();
    t_priority();
    t_bypass();
    t_same_cycle();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      report();
    end
  end
endmodule